// File: doc/BRIEF.md
# Program Counter Branch and Call Unit

This block holds a byte-addressed 16-bit program counter and an 8-bit stack pointer into internal RAM, and works out the next fetch address for each instruction. An upstream decoder presents a branch kind, up to two operand bytes, the instruction length and the condition inputs together with a `step` strobe. For each step the unit advances sequentially, jumps, branches relative, calls or returns.

It forms targets in three ways. A long target is a full 16-bit address. An absolute target is an 11-bit address placed inside the 2 KB page of the following instruction. A relative target is a signed byte added to the address of the following instruction. Calls save the return address to the stack over a registered RAM write port, low byte first. Returns read it back through a synchronous-read port. While these stack transfers run, the unit raises `busy` and ignores `step`.

Top module: `pcu_top`

## Requirements
- R1: After a synchronous reset, `pc` is 0000h, `sp` is 07h, and `busy`, `ram_we`, `ram_re` and `cy_wr` are low.
- R2: An accepted step (`step` high while `busy` is low) of kind 0 (sequential), or an untaken conditional branch, sets `pc` to `pc + ins_len` at the next clock edge. With `step` low, `pc`, `sp` and the RAM strobes stay put.
- R3: Kind 1 (long jump) loads `pc` with `{op_hi, op_lo}`.
- R4: Kind 2 (absolute jump) loads `pc` with bits 15..11 of `pc + ins_len`, then `op_hi[2:0]`, then `op_lo`. The page therefore comes from the following instruction, even when that instruction sits across a page boundary.
- R5: Kind 3 (short jump) and every taken conditional branch load `pc` with `pc + ins_len` plus `op_lo` sign-extended. The result wraps modulo 64 K.
- R6: Kind 7 branches when `cy_in` is 1, kind 8 when `cy_in` is 0, kind 9 when `acc_zero` is 1, and kind 10 when `acc_zero` is 0.
- R7: Kind 11 (decrement and branch) branches exactly when `djnz_val - 1` is non-zero, so 00h branches and 01h falls through.
- R8: Kind 12 (compare and branch) branches when `cmp_dst != cmp_src`. One cycle after acceptance, it pulses `cy_wr` with `cy_val = (cmp_dst < cmp_src)` unsigned, whether or not the branch is taken.
- R9: Kind 4 (long call) and kind 5 (absolute call) form their target as in R3 and R4. They write the return address `pc + ins_len` as its low byte to `sp+1` and then its high byte to `sp+2`, one write on each of two consecutive cycles. `sp` ends 2 higher.
- R10: Kind 6 (return) reads address `sp` (high byte) and then `sp-1` (low byte) on consecutive cycles. Three cycles later it loads `pc` with those two bytes, and `sp` ends 2 lower.
- R11: `busy` stays high for 1 cycle after a call and for 3 cycles after a return. A `step` seen while `busy` is high has no effect, and `ram_we` and `ram_re` are never high together.
- R12: `sp` wraps modulo 256 on push and pop, and pushed bytes go to the wrapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Instruction present; accepted when busy is low |
| kind | input | 4 | Branch kind code 0..12 |
| op_lo | input | 8 | Low operand byte / relative offset |
| op_hi | input | 8 | High operand byte |
| ins_len | input | 2 | Length in bytes of the current instruction |
| cy_in | input | 1 | Carry flag |
| acc_zero | input | 1 | Accumulator equals zero |
| djnz_val | input | 8 | Counter byte before decrement |
| cmp_dst | input | 8 | Compare destination byte |
| cmp_src | input | 8 | Compare source byte |
| ram_rdata | input | 8 | Stack RAM read data, one cycle after the read strobe |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Stack transfer in progress |
| ram_we | output | 1 | Stack RAM write strobe |
| ram_re | output | 1 | Stack RAM read strobe |
| ram_addr | output | 8 | Stack RAM address |
| ram_wdata | output | 8 | Stack RAM write data |
| cy_wr | output | 1 | Carry update strobe from a compare |
| cy_val | output | 1 | Carry value to write |

## Verification
On every cycle, the assertions check the one-step relations: sequential advance, long jump loading, the first pushed byte and its address, the two-step stack pointer move, the first pop address, the compare carry, the idle hold and the exclusive RAM strobes. The bench scenarios cover what needs memory across many instructions. These include deep nesting that wraps the stack pointer, with returns that come back in reverse order, absolute targets at page crossings, full sweeps of relative offsets and decrement values, and steps ignored during a busy window.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [3:0] {
    BK_SEQ   = 4'd0,
    BK_LJMP  = 4'd1,
    BK_AJMP  = 4'd2,
    BK_SJMP  = 4'd3,
    BK_LCALL = 4'd4,
    BK_ACALL = 4'd5,
    BK_RET   = 4'd6,
    BK_JC    = 4'd7,
    BK_JNC   = 4'd8,
    BK_JZ    = 4'd9,
    BK_JNZ   = 4'd10,
    BK_DJNZ  = 4'd11,
    BK_CJNE  = 4'd12
  } br_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_POP_A,
    ST_POP_B,
    ST_POP_C
  } stk_state_e;

endpackage

// File: rtl/pcu_target.sv
module pcu_target
  import pcu_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int PAGE_W = 11,
  parameter int LW     = 2
) (
  input  logic [AW-1:0] pc,
  input  br_kind_e      kind,
  input  logic [DW-1:0] op_lo,
  input  logic [DW-1:0] op_hi,
  input  logic [LW-1:0] ins_len,
  input  logic          cy_in,
  input  logic          acc_zero,
  input  logic [DW-1:0] djnz_val,
  input  logic [DW-1:0] cmp_dst,
  input  logic [DW-1:0] cmp_src,
  output logic [AW-1:0] seq,
  output logic [AW-1:0] nxt,
  output logic          is_call,
  output logic          is_ret,
  output logic          cmp_lt
);
  localparam int IN_PAGE_HI = PAGE_W - DW;

  logic [AW-1:0] long_t, abs_t, rel_t;
  logic          cond_take;

  assign seq    = pc + AW'(ins_len);
  assign long_t = {op_hi, op_lo};
  assign abs_t  = {seq[AW-1:PAGE_W], op_hi[IN_PAGE_HI-1:0], op_lo};
  assign rel_t  = seq + {{(AW-DW){op_lo[DW-1]}}, op_lo};
  assign cmp_lt = cmp_dst < cmp_src;

  always_comb begin
    unique case (kind)
      BK_JC:   cond_take = cy_in;
      BK_JNC:  cond_take = !cy_in;
      BK_JZ:   cond_take = acc_zero;
      BK_JNZ:  cond_take = !acc_zero;
      BK_DJNZ: cond_take = (djnz_val != DW'(1));
      BK_CJNE: cond_take = (cmp_dst != cmp_src);
      default: cond_take = 1'b0;
    endcase
  end

  always_comb begin
    unique case (kind)
      BK_LJMP, BK_LCALL: nxt = long_t;
      BK_AJMP, BK_ACALL: nxt = abs_t;
      BK_SJMP:           nxt = rel_t;
      BK_RET:            nxt = pc;
      BK_JC, BK_JNC, BK_JZ, BK_JNZ, BK_DJNZ, BK_CJNE:
                         nxt = cond_take ? rel_t : seq;
      default:           nxt = seq;
    endcase
  end

  assign is_call = (kind == BK_LCALL) || (kind == BK_ACALL);
  assign is_ret  = (kind == BK_RET);

endmodule

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
#(
  parameter int            AW     = 16,
  parameter int            DW     = 8,
  parameter logic [AW-1:0] PC_RST = '0,
  parameter logic [DW-1:0] SP_RST = 8'h07
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  br_kind_e      kind,
  input  logic [AW-1:0] seq,
  input  logic [AW-1:0] nxt,
  input  logic          is_call,
  input  logic          is_ret,
  input  logic          cmp_lt,
  input  logic [DW-1:0] ram_rdata,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] sp,
  output logic          busy,
  output logic          ram_we,
  output logic          ram_re,
  output logic [DW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          cy_wr,
  output logic          cy_val
);
  stk_state_e    state;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] sp_q, hold_q, addr_q, wdata_q;
  logic          we_q, re_q, cyw_q, cyv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pc_q    <= PC_RST;
      sp_q    <= SP_RST;
      hold_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      cyw_q   <= 1'b0;
      cyv_q   <= 1'b0;
    end else begin
      we_q  <= 1'b0;
      re_q  <= 1'b0;
      cyw_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (step) begin
            pc_q <= nxt;
            if (kind == BK_CJNE) begin
              cyw_q <= 1'b1;
              cyv_q <= cmp_lt;
            end
            if (is_call) begin
              we_q    <= 1'b1;
              addr_q  <= sp_q + DW'(1);
              sp_q    <= sp_q + DW'(1);
              wdata_q <= seq[DW-1:0];
              hold_q  <= seq[AW-1:DW];
              state   <= ST_PUSH;
            end else if (is_ret) begin
              re_q   <= 1'b1;
              addr_q <= sp_q;
              sp_q   <= sp_q - DW'(1);
              state  <= ST_POP_A;
            end
          end
        end
        ST_PUSH: begin
          we_q    <= 1'b1;
          addr_q  <= sp_q + DW'(1);
          sp_q    <= sp_q + DW'(1);
          wdata_q <= hold_q;
          state   <= ST_IDLE;
        end
        ST_POP_A: begin
          re_q   <= 1'b1;
          addr_q <= sp_q;
          sp_q   <= sp_q - DW'(1);
          state  <= ST_POP_B;
        end
        ST_POP_B: begin
          hold_q <= ram_rdata;
          state  <= ST_POP_C;
        end
        ST_POP_C: begin
          pc_q  <= {hold_q, ram_rdata};
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pc        = pc_q;
  assign sp        = sp_q;
  assign busy      = (state != ST_IDLE);
  assign ram_we    = we_q;
  assign ram_re    = re_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = wdata_q;
  assign cy_wr     = cyw_q;
  assign cy_val    = cyv_q;

endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int            AW     = 16,
  parameter int            DW     = 8,
  parameter int            PAGE_W = 11,
  parameter int            LW     = 2,
  parameter logic [AW-1:0] PC_RST = '0,
  parameter logic [DW-1:0] SP_RST = 8'h07
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [3:0]    kind,
  input  logic [DW-1:0] op_lo,
  input  logic [DW-1:0] op_hi,
  input  logic [LW-1:0] ins_len,
  input  logic          cy_in,
  input  logic          acc_zero,
  input  logic [DW-1:0] djnz_val,
  input  logic [DW-1:0] cmp_dst,
  input  logic [DW-1:0] cmp_src,
  input  logic [DW-1:0] ram_rdata,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] sp,
  output logic          busy,
  output logic          ram_we,
  output logic          ram_re,
  output logic [DW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          cy_wr,
  output logic          cy_val
);
  br_kind_e      kind_e;
  logic [AW-1:0] seq, nxt;
  logic          is_call, is_ret, cmp_lt;

  assign kind_e = br_kind_e'(kind);

  pcu_target #(.AW(AW), .DW(DW), .PAGE_W(PAGE_W), .LW(LW)) u_target (
    .pc       (pc),
    .kind     (kind_e),
    .op_lo    (op_lo),
    .op_hi    (op_hi),
    .ins_len  (ins_len),
    .cy_in    (cy_in),
    .acc_zero (acc_zero),
    .djnz_val (djnz_val),
    .cmp_dst  (cmp_dst),
    .cmp_src  (cmp_src),
    .seq      (seq),
    .nxt      (nxt),
    .is_call  (is_call),
    .is_ret   (is_ret),
    .cmp_lt   (cmp_lt)
  );

  pcu_ctrl #(.AW(AW), .DW(DW), .PC_RST(PC_RST), .SP_RST(SP_RST)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .kind      (kind_e),
    .seq       (seq),
    .nxt       (nxt),
    .is_call   (is_call),
    .is_ret    (is_ret),
    .cmp_lt    (cmp_lt),
    .ram_rdata (ram_rdata),
    .pc        (pc),
    .sp        (sp),
    .busy      (busy),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .cy_wr     (cy_wr),
    .cy_val    (cy_val)
  );

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int LW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          step,
  input logic          busy,
  input logic [3:0]    kind,
  input logic [DW-1:0] op_lo,
  input logic [DW-1:0] op_hi,
  input logic [LW-1:0] ins_len,
  input logic [DW-1:0] cmp_dst,
  input logic [DW-1:0] cmp_src,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] sp,
  input logic          ram_we,
  input logic          ram_re,
  input logic [DW-1:0] ram_addr,
  input logic [DW-1:0] ram_wdata,
  input logic          cy_wr,
  input logic          cy_val
);
  logic          acc, call_acc;
  logic [AW-1:0] seq_c;
  logic [DW-1:0] seq_lo;

  assign acc      = step && !busy;
  assign call_acc = acc && (kind == 4'd4 || kind == 4'd5);
  assign seq_c    = pc + AW'(ins_len);
  assign seq_lo   = seq_c[DW-1:0];

  p_seq_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && kind == 4'd0) |=> (pc == $past(seq_c)));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !step) |=> (pc == $past(pc) && sp == $past(sp) && !ram_we && !ram_re));

  p_long_jump_r3: assert property (@(posedge clk) disable iff (rst)
    (acc && kind == 4'd1) |=> (pc == {$past(op_hi), $past(op_lo)}));

  p_cmp_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && kind == 4'd12) |=> (cy_wr && cy_val == $past(cmp_dst < cmp_src)));

  p_push_low_r9: assert property (@(posedge clk) disable iff (rst)
    call_acc |=> (ram_we && ram_wdata == $past(seq_lo) && ram_addr == $past(sp) + DW'(1)));

  p_sp_two_r9: assert property (@(posedge clk) disable iff (rst)
    call_acc |-> ##2 (sp == $past(sp, 2) + DW'(2) && !busy));

  p_pop_first_r10: assert property (@(posedge clk) disable iff (rst)
    (acc && kind == 4'd6) |=> (ram_re && ram_addr == $past(sp) && busy));

  p_port_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_re));

endmodule

bind pcu_top pcu_checker #(.AW(AW), .DW(DW), .LW(LW)) u_pcu_checker (
  .clk       (clk),
  .rst       (rst),
  .step      (step),
  .busy      (busy),
  .kind      (kind),
  .op_lo     (op_lo),
  .op_hi     (op_hi),
  .ins_len   (ins_len),
  .cmp_dst   (cmp_dst),
  .cmp_src   (cmp_src),
  .pc        (pc),
  .sp        (sp),
  .ram_we    (ram_we),
  .ram_re    (ram_re),
  .ram_addr  (ram_addr),
  .ram_wdata (ram_wdata),
  .cy_wr     (cy_wr),
  .cy_val    (cy_val)
);

// File: tb/test_pcu_top.sv
module test_pcu_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0;
  logic [3:0]  kind = '0;
  logic [7:0]  op_lo = '0, op_hi = '0;
  logic [1:0]  ins_len = 2'd1;
  logic        cy_in = 1'b0, acc_zero = 1'b0;
  logic [7:0]  djnz_val = '0, cmp_dst = '0, cmp_src = '0;
  logic [7:0]  ram_rdata;
  logic [15:0] pc;
  logic [7:0]  sp, ram_addr, ram_wdata;
  logic        busy, ram_we, ram_re, cy_wr, cy_val;

  logic [7:0]  mem [256];
  logic [15:0] rstk [128];
  int          n_chk = 0, n_fail = 0, busy_cnt = 0;
  logic [15:0] m_pc;
  logic [7:0]  m_sp;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  pcu_top i_pcu_top (
    .clk(clk), .rst(rst), .step(step), .kind(kind), .op_lo(op_lo), .op_hi(op_hi),
    .ins_len(ins_len), .cy_in(cy_in), .acc_zero(acc_zero), .djnz_val(djnz_val),
    .cmp_dst(cmp_dst), .cmp_src(cmp_src), .ram_rdata(ram_rdata), .pc(pc), .sp(sp),
    .busy(busy), .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .cy_wr(cy_wr), .cy_val(cy_val)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] k, input logic [7:0] lo, input logic [7:0] hi,
                     input logic [1:0] len);
    kind = k; op_lo = lo; op_hi = hi; ins_len = len; step = 1'b1;
    @(posedge clk); @(negedge clk);
    step = 1'b0;
    busy_cnt = 0;
    while (busy) begin
      @(negedge clk);
      busy_cnt++;
    end
  endtask

  task automatic go_to(input logic [15:0] a);
    run(4'd1, a[7:0], a[15:8], 2'd3);
    m_pc = a;
  endtask

  function automatic logic [15:0] rel(input logic [15:0] base, input logic [1:0] len,
                                      input logic [7:0] off);
    return base + 16'(len) + {{8{off[7]}}, off};
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog: actual no completion expected finish within %0d cycles", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pc", pc, 16'h0000);
    chk("R1 sp", sp, 8'h07);
    chk("R1 strobes", {busy, ram_we, ram_re, cy_wr}, 4'b0000);
    m_pc = 16'h0000; m_sp = 8'h07;

    // R2 sequential advance and idle hold
    for (int i = 0; i < 9; i++) begin
      logic [1:0] l;
      l = 2'(i % 3 + 1);
      run(4'd0, 8'hAA, 8'h55, l);
      m_pc = m_pc + 16'(l);
      chk("R2 seq", pc, m_pc);
    end
    repeat (4) @(negedge clk);
    chk("R2 idle hold", {pc, sp}, {m_pc, m_sp});

    // R3 long jump sweep
    for (int i = 0; i < 64; i++) begin
      logic [15:0] t;
      t = 16'(i * 1031 + 7);
      run(4'd1, t[7:0], t[15:8], 2'd3);
      chk("R3 long jump", pc, t);
    end

    // R4 absolute jump, including page crossing
    for (int b = 0; b < 4; b++) begin
      logic [15:0] base;
      base = (b == 0) ? 16'h07FE : (b == 1) ? 16'h1234 : (b == 2) ? 16'hF7FF : 16'hFFFE;
      for (int a = 0; a < 8; a++) begin
        logic [10:0] a11;
        logic [15:0] s;
        a11 = 11'(a * 291 + 5);
        go_to(base);
        s = base + 16'd2;
        run(4'd2, a11[7:0], {5'b10101, a11[10:8]}, 2'd2);
        chk("R4 absolute", pc, {s[15:11], a11});
      end
    end

    // R5 short jump, every offset
    for (int o = 0; o < 256; o++) begin
      logic [15:0] base;
      base = (o % 2 == 0) ? 16'h4000 : 16'h0010;
      go_to(base);
      run(4'd3, 8'(o), 8'h00, 2'd2);
      chk("R5 short", pc, rel(base, 2'd2, 8'(o)));
    end

    // R6 carry and zero conditions
    for (int k = 7; k <= 10; k++) begin
      for (int f = 0; f < 2; f++) begin
        logic take;
        cy_in = f[0]; acc_zero = f[0];
        take = (k == 7) ? f[0] : (k == 8) ? !f[0] : (k == 9) ? f[0] : !f[0];
        go_to(16'h2000);
        run(4'(k), 8'hF0, 8'h00, 2'd2);
        chk("R6 cond", pc, take ? rel(16'h2000, 2'd2, 8'hF0) : 16'h2002);
      end
    end
    cy_in = 1'b0; acc_zero = 1'b0;

    // R7 decrement and branch, every counter value
    for (int v = 0; v < 256; v++) begin
      djnz_val = 8'(v);
      go_to(16'h3000);
      run(4'd11, 8'hF0, 8'h00, 2'd2);
      chk("R7 djnz", pc, (v != 1) ? rel(16'h3000, 2'd2, 8'hF0) : 16'h3002);
    end

    // R8 compare and branch, carry from unsigned less-than
    for (int d = 0; d < 16; d++) begin
      for (int s = 0; s < 16; s++) begin
        cmp_dst = 8'(d * 17); cmp_src = 8'(s * 17 + (s % 3 == 0 ? 0 : 1));
        go_to(16'h5000);
        run(4'd12, 8'h20, 8'h00, 2'd3);
        chk("R8 cmp pc", pc, (cmp_dst != cmp_src) ? 16'h5023 : 16'h5003);
        chk("R8 cmp carry", {cy_wr, cy_val}, {1'b1, cmp_dst < cmp_src});
      end
    end

    // R9 nested calls, R12 stack pointer wraps, R11 busy length
    go_to(16'h0100);
    for (int i = 0; i < 125; i++) begin
      logic [15:0] ret, tgt, s;
      logic [7:0]  sp0;
      logic [1:0]  l;
      sp0 = m_sp;
      if (i % 2 == 0) begin
        l = 2'd3;
        ret = m_pc + 16'd3;
        tgt = 16'(i * 523 + 16'h0200);
        run(4'd4, tgt[7:0], tgt[15:8], l);
      end else begin
        l = 2'd2;
        ret = m_pc + 16'd2;
        s = ret;
        tgt = {s[15:11], 11'(i * 37)};
        run(4'd5, tgt[7:0], {5'b00000, tgt[10:8]}, l);
      end
      rstk[i] = ret;
      m_pc = tgt;
      m_sp = sp0 + 8'd2;
      chk("R9 call pc", pc, m_pc);
      chk("R12 call sp", sp, m_sp);
      chk("R11 call busy", busy_cnt, 1);
      @(negedge clk);
      chk("R9 push low", mem[8'(sp0 + 8'd1)], ret[7:0]);
      chk("R9 push high", mem[8'(sp0 + 8'd2)], ret[15:8]);
    end
    for (int i = 124; i >= 0; i--) begin
      run(4'd6, 8'h00, 8'h00, 2'd1);
      m_sp = m_sp - 8'd2;
      chk("R10 ret pc", pc, rstk[i]);
      chk("R12 ret sp", sp, m_sp);
      chk("R11 ret busy", busy_cnt, 3);
    end
    chk("R10 stack back to reset", sp, 8'h07);

    // R11 step during busy is ignored
    go_to(16'h6000);
    kind = 4'd4; op_lo = 8'h34; op_hi = 8'h12; ins_len = 2'd3; step = 1'b1;
    @(posedge clk); @(negedge clk);
    kind = 4'd1; op_lo = 8'hEF; op_hi = 8'hBE;
    chk("R11 busy during push", busy, 1'b1);
    @(posedge clk); @(negedge clk);
    step = 1'b0;
    chk("R11 ignored step pc", pc, 16'h1234);
    chk("R11 ignored step sp", sp, 8'h09);
    @(negedge clk);
    run(4'd6, 8'h00, 8'h00, 2'd1);
    chk("R10 ret after ignored", pc, 16'h6003);
    chk("R10 sp after ignored", sp, 8'h07);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule